// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Encoder

This block gathers a set of level-sensitive interrupt lines from peripherals into one interrupt request toward the processor. Every line is brought into the clock domain through a short synchronizer chain and then latched into a source register that mirrors its level. An enable mask selects which source bits count as pending. Whenever at least one bit is pending, the registered interrupt output is high.

Software services the interrupt by reading the source register. The read does not return the raw bits. It returns an encoded vector for the pending line with the lowest number, which is also the line of highest priority. The mask is a read/write register that can be written as a full 16-bit word or one byte lane at a time. A 32-bit access by the processor reaches the block as two 16-bit accesses, one at offset 0 and one at offset 2. Reads complete with a one-cycle response strobe. A read of an offset with no register behind it also raises an error strobe.

Top module: `lirq_encoder`

## Requirements
- R1: Each source bit follows the level of its input line. It is set while the line is high and cleared once the line is low, with no edge memory.
- R2: The interrupt output is high exactly when (source AND mask) is non-zero, one clock after that term changes.
- R3: A read at byte offset 0 returns ((i+1) << 2), where i is the lowest-numbered pending line, so line 0 reads as 4 and line 15 reads as 64. It returns 0 when nothing is pending.
- R4: After reset the mask reads 0x0010 (only line 4 enabled), the source vector reads 0 and the interrupt output is low.
- R5: A write at byte offset 2 with both byte enables set replaces the whole mask. The output follows the new mask on the next clock.
- R6: Byte enable bit 0 selects mask bits 7:0 and byte enable bit 1 selects bits 15:8. A lane whose enable is clear keeps its current value.
- R7: Writes to offset 0 or to any unmapped offset (4 to 14) leave the mask and the output unchanged and raise no error.
- R8: A read of an unmapped offset returns 0 and raises the error strobe for exactly one cycle, in the same cycle as the read response.
- R9: Read data and the read-valid strobe appear on the clock edge after the request. A read at offset 2 returns the mask.
- R10: A change on an input line reaches the source register on the third clock edge and the interrupt output on the fourth clock edge.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 16 | Peripheral interrupt levels, asynchronous |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset; bit 0 ignored |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte lane enables for writes |
| bus_rdata | output | 16 | Read data, registered |
| bus_rvalid | output | 1 | Read response strobe |
| bus_err | output | 1 | Unmapped-read strobe |
| irq_out | output | 1 | Combined interrupt request, registered |

## Verification
A line change is due at the source register three edges later and at the interrupt output four edges later. The bench checks that the output is still low after the third edge and high after the fourth. A mask write shows in the mask at the write edge and in the output one edge after that, so the output is sampled only after that extra edge. A read is driven and then sampled at the falling edge that follows the capturing rising edge. Every comparison happens at a falling edge, where no register is changing.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
   // register word indices (byte offset >> 1)
   localparam int unsigned WORD_SOURCE = 0;
   localparam int unsigned WORD_MASK   = 1;

   typedef enum logic [1:0] {
      REG_SOURCE = 2'd0,
      REG_MASK   = 2'd1,
      REG_NONE   = 2'd2
   } reg_sel_e;

   function automatic reg_sel_e decode_word(input int unsigned word);
      if (word == WORD_SOURCE)    return REG_SOURCE;
      else if (word == WORD_MASK) return REG_MASK;
      else                        return REG_NONE;
   endfunction
endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 0) begin : g_bad_stages
      $error("lirq_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign dout = din;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
         end else begin
            stage_q[0] <= din;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
         end
      end
      assign dout = stage_q[STAGES-1];
   end
endmodule

// File: rtl/lirq_prio_enc.sv
module lirq_prio_enc #(
   parameter int LINES = 16,
   parameter int OUT_W = 16,
   parameter int SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] pending,
   output logic [OUT_W-1:0] vec
);
   localparam int VEC_TOP = (LINES << SHIFT);

   if (VEC_TOP >= (1 << OUT_W) && OUT_W < 31) begin : g_bad_width
      $error("lirq_prio_enc: OUT_W too narrow for encoded vector");
   end

   // lowest index wins: scan downward so the last hit is the lowest
   always_comb begin
      vec = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (pending[i]) vec = OUT_W'((i + 1) << SHIFT);
      end
   end

   // checker: decode the vector back and confirm it names the lowest pending line
   logic chk_ok;
   always_comb begin
      int idx;
      idx    = int'(vec >> SHIFT) - 1;
      chk_ok = 1'b1;
      if (vec == '0) begin
         chk_ok = (pending == '0);
      end else if (idx < 0 || idx >= LINES) begin
         chk_ok = 1'b0;
      end else begin
         for (int j = 0; j < LINES; j++) begin
            if (j == idx && !pending[j]) chk_ok = 1'b0;
            if (j < idx && pending[j])   chk_ok = 1'b0;
         end
      end
   end

   assert_vec_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n) chk_ok)
      else $error("encoded vector does not name lowest pending line");
endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
   import lirq_pkg::*;
#(
   parameter int             DATA_W   = 16,
   parameter int             ADDR_W   = 4,
   parameter logic [DATA_W-1:0] MASK_RST = 16'h0010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W/8-1:0] be,
   input  logic [DATA_W-1:0] vec,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              err
);
   localparam int LANES = DATA_W / 8;

   if (DATA_W % 8 != 0) begin : g_bad_data_w
      $error("lirq_regs: DATA_W must be a multiple of 8");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("lirq_regs: ADDR_W must cover two halfword registers");
   end

   reg_sel_e which;
   logic     mask_wr, rd_req;

   assign which   = decode_word(int'(addr[ADDR_W-1:1]));
   assign mask_wr = sel && wr && (which == REG_MASK);
   assign rd_req  = sel && !wr;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                mask_q[b*8 +: 8] <= MASK_RST[b*8 +: 8];
         else if (mask_wr && be[b]) mask_q[b*8 +: 8] <= wdata[b*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
         err    <= 1'b0;
      end else begin
         rvalid <= rd_req;
         err    <= rd_req && (which == REG_NONE);
         if (rd_req) begin
            unique case (which)
               REG_SOURCE: rdata <= vec;
               REG_MASK:   rdata <= mask_q;
               default:    rdata <= '0;
            endcase
         end else begin
            rdata <= '0;
         end
      end
   end

   assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(mask_q))
      else $error("mask changed without a mask write");

   assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (rvalid && rdata == '0))
      else $error("error strobe without zero read response");

   assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rvalid)
      else $error("read response missing one cycle after request");

   assert_no_spurious_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rvalid)
      else $error("read response without request");
endmodule

// File: rtl/lirq_encoder.sv
module lirq_encoder #(
   parameter int NUM_LINES   = 16,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_SHIFT   = 2,
   parameter logic [DATA_W-1:0] MASK_RST = 16'h0010
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_in,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic [DATA_W/8-1:0]  bus_be,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 bus_rvalid,
   output logic                 bus_err,
   output logic                 irq_out
);
   if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
      $error("lirq_encoder: NUM_LINES must be 1..DATA_W");
   end

   logic [NUM_LINES-1:0] synced, src_q, pending;
   logic [DATA_W-1:0]    mask_q, vec;
   logic                 irq_q;

   lirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(line_in), .dout(synced)
   );

   // source register mirrors the synchronized level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= synced;
   end

   assign pending = src_q & mask_q[NUM_LINES-1:0];

   lirq_prio_enc #(.LINES(NUM_LINES), .OUT_W(DATA_W), .SHIFT(VEC_SHIFT)) u_enc (
      .clk(clk), .rst_n(rst_n), .pending(pending), .vec(vec)
   );

   lirq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK_RST(MASK_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .be(bus_be), .vec(vec), .mask_q(mask_q),
      .rdata(bus_rdata), .rvalid(bus_rvalid), .err(bus_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pending;
   end

   assign irq_out = irq_q;

   assert_irq_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (vec != '0) |=> irq_out)
      else $error("interrupt not raised for pending line");

   assert_irq_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (vec == '0) |=> !irq_out)
      else $error("interrupt raised with nothing pending");
endmodule

// File: tb/lirq_encoder_test.sv
module lirq_encoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] line_in = '0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [1:0]  bus_be = '0;
   logic [15:0] bus_rdata;
   logic        bus_rvalid, bus_err, irq_out;

   int n_checks = 0;
   int n_fails  = 0;
   logic [15:0] mdl_mask;
   logic        finished = 1'b0;

   always #4 clk = ~clk;

   lirq_encoder uut (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_be(bus_be), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .bus_err(bus_err), .irq_out(irq_out)
   );

   function automatic int exp_vec(input logic [15:0] l, input logic [15:0] m);
      for (int i = 0; i < 16; i++) if (l[i] && m[i]) return (i + 1) << 2;
      return 0;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [15:0] d,
                           output logic rv, output logic er);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata; rv = bus_rvalid; er = bus_err;
      bus_sel = 1'b0;
   endtask

   task automatic settle_lines();
      repeat (5) @(negedge clk);
   endtask

   task automatic check_source(input string req);
      logic [15:0] d; logic rv, er;
      bus_read(4'h0, d, rv, er);
      check(req, int'(d), exp_vec(line_in, mdl_mask));
      check(req, int'(rv), 1);
   endtask

   task automatic check_mask(input string req);
      logic [15:0] d; logic rv, er;
      bus_read(4'h2, d, rv, er);
      check(req, int'(d), int'(mdl_mask));
   endtask

   task automatic t_reset();
      check("R4 irq", int'(irq_out), 0);
      check_mask("R4 mask");
      check_source("R4 source");
   endtask

   task automatic t_latency();
      line_in[4] = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 irq before 4th edge", int'(irq_out), 0);
      @(negedge clk);
      check("R10 irq at 4th edge", int'(irq_out), 1);
      check_source("R3 line4 vector");
   endtask

   task automatic t_level_follow();
      line_in[2] = 1'b1;
      settle_lines();
      check_source("R1 masked line ignored");
      line_in[4] = 1'b0;
      settle_lines();
      check_source("R1 source cleared");
      check("R2 irq low when none pending", int'(irq_out), 0);
   endtask

   task automatic t_full_mask();
      bus_write(4'h2, 16'hFFFF, 2'b11);
      mdl_mask = 16'hFFFF;
      check("R5 irq not yet", int'(irq_out), 0);
      @(negedge clk);
      check("R5 irq after mask write", int'(irq_out), 1);
      check_source("R5 line2 vector");
      check_mask("R5 mask read");
   endtask

   task automatic t_byte_lanes();
      bus_write(4'h2, 16'h55AB, 2'b01);
      mdl_mask = 16'hFFAB;
      check_mask("R6 low lane");
      bus_write(4'h3, 16'h12CD, 2'b10);
      mdl_mask = 16'h12AB;
      check_mask("R6 high lane");
   endtask

   task automatic t_priority();
      line_in[15] = 1'b1; line_in[9] = 1'b1; line_in[3] = 1'b1;
      settle_lines();
      check_source("R3 lowest of 3,9");
      bus_write(4'h2, 16'h8000, 2'b11);
      mdl_mask = 16'h8000;
      @(negedge clk);
      check_source("R3 line15 vector");
      check("R2 irq high line15", int'(irq_out), 1);
   endtask

   task automatic t_ignored_writes();
      bus_write(4'h0, 16'h0000, 2'b11);
      check("R7 no err on write", int'(bus_err), 0);
      bus_write(4'h6, 16'h0000, 2'b11);
      check("R7 no err on write", int'(bus_err), 0);
      bus_write(4'hE, 16'h0000, 2'b11);
      @(negedge clk);
      check_mask("R7 mask kept");
      check("R7 irq kept", int'(irq_out), 1);
   endtask

   task automatic t_unmapped_read();
      logic [15:0] d; logic rv, er;
      bus_read(4'h8, d, rv, er);
      check("R8 data", int'(d), 0);
      check("R8 err", int'(er), 1);
      check("R9 rvalid", int'(rv), 1);
      @(negedge clk);
      check("R8 err one cycle", int'(bus_err), 0);
      check("R9 rvalid drops", int'(bus_rvalid), 0);
   endtask

   task automatic t_mask_off();
      bus_write(4'h2, 16'h0000, 2'b11);
      mdl_mask = 16'h0000;
      @(negedge clk);
      check("R2 irq low with mask zero", int'(irq_out), 0);
      check_source("R3 zero vector");
      line_in = '0;
      bus_write(4'h2, 16'h0001, 2'b11);
      mdl_mask = 16'h0001;
      line_in[0] = 1'b1;
      settle_lines();
      check_source("R3 line0 vector");
      check("R2 irq line0", int'(irq_out), 1);
   endtask

   initial begin
      mdl_mask = 16'h0010;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latency();
      t_level_follow();
      t_full_mask();
      t_byte_lanes();
      t_priority();
      t_ignored_writes();
      t_unmapped_read();
      t_mask_off();
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end
endmodule